// File: doc/BRIEF.md
# T1 Receive Signaling Capture

This block pulls robbed-bit signaling out of the received DS0 bytes of a 24-channel T1 trunk and keeps one signaling nibble for each channel. The framer upstream supplies each byte with its frame number inside the multiframe and its channel number. The block also receives the trunk mode, the multiframe sync status, a debounce enable and two spare bits set by the host. In extended-superframe mode the four bits form A, B, C and D. In D4 mode only A and B are captured, and the host's spare bits fill the two lower positions.

Committed nibbles can be read in two ways. A host read port returns them one cycle after an address is given. A serial control stream carries them in the low nibble of the stream channel that matches each T1 channel. Every other bit position is tristated. A stream-enable input turns the whole stream off, and so does reset. While multiframe sync is lost, capture stops and the stored values stay as they are. An optional debounce commits a new nibble only after it has been seen unchanged for 48 frames (6 ms).

Top module: `t1_rxsig_capture`

## Requirements
- R1: In ESF mode (`esf_mode`=1), bit 0 of `rx_byte` in frames 6, 12, 18 and 24 gives A, B, C and D. These land in nibble bits 3, 2, 1 and 0. The nibble is complete when the frame-24 byte of that channel arrives.
- R2: In D4 mode (`esf_mode`=0), only frames 6 and 12 are sampled, giving A in bit 3 and B in bit 2. The nibble is complete when the frame-12 byte arrives. Bytes of frames 13 to 24 change nothing.
- R3: In D4 mode, bits 1 and 0 of every nibble on the host port and on the stream show `spare_bits[1]` and `spare_bits[0]`. They follow `spare_bits` at once, without a new capture.
- R4: While `mf_sync`=0, received bytes neither change a stored nibble nor advance the capture.
- R5: With `dbnc_en`=0, a completed nibble is committed in the cycle in which its last byte is taken.
- R6: With `dbnc_en`=1, a completed nibble is committed only when it is identical to the nibbles completed over the previous 48 frames. In ESF this is the third identical multiframe in a row. A differing nibble restarts the count.
- R7: The stream position (`str_ch`, `str_bit`) is given one cycle ahead of the registered output. For channels 0 to 23 at bit indices 3 to 0, `ser_oe`=1 and `ser_out` is that nibble bit. Bit indices 7 to 4 and channels 24 to 31 give `ser_oe`=0.
- R8: `ser_oe` is 0 in the cycle after `strm_en` is low or `rst` is high.
- R9: `host_rdata` shows the nibble at `host_addr` one cycle later. Reading has no side effect. Addresses 24 to 31 read 0.
- R10: After reset, all stored nibbles and all debounce state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_frame | input | 5 | Frame number in the multiframe, 1 to 24 |
| rx_slot | input | 5 | T1 channel, 0 to 23 |
| rx_byte | input | 8 | Received DS0 byte; bit 0 is the robbed bit |
| esf_mode | input | 1 | 1 = ESF (ABCD), 0 = D4 (AB) |
| mf_sync | input | 1 | 1 = multiframe sync present |
| dbnc_en | input | 1 | 6 ms debounce enable |
| spare_bits | input | 2 | Host bits shown in the C/D positions in D4 |
| strm_en | input | 1 | Serial stream enable |
| str_ch | input | 5 | Stream channel being sent, 0 to 31 |
| str_bit | input | 3 | Bit index within the stream channel, 7 first |
| ser_out | output | 1 | Serial stream data |
| ser_oe | output | 1 | Serial stream drive enable |
| host_addr | input | 5 | Host read channel |
| host_rdata | output | 4 | Host read nibble |

## Verification
A nibble is committed on the clock edge that takes its last byte. The bench therefore reads the host port no earlier than the edge after that. It sets the address at a falling edge and compares `host_rdata` at the next falling edge, one register later. Each stream position follows the same rule: it is driven at a falling edge and `ser_out` and `ser_oe` are compared one falling edge later. Debounce checks read between whole multiframes. This places every comparison where the count of 24-frame steps puts the commit, either before it or after it.

// File: rtl/t1rs_pkg.sv
package t1rs_pkg;

  localparam int SIG_STRIDE    = 6;   // robbed-bit frames recur every 6 frames
  localparam int ESF_MF_FRAMES = 24;
  localparam int D4_MF_FRAMES  = 12;

  typedef logic [3:0] sig_nib_t;

  typedef struct packed {
    logic       hit;   // this frame carries a signaling bit
    logic       last;  // this frame completes the nibble
    logic [1:0] pos;   // nibble bit the frame fills
  } frame_role_t;

  function automatic frame_role_t frame_role(input logic [4:0] frame, input logic esf);
    frame_role_t r;
    int unsigned f;
    int unsigned q;
    f = int'(frame);
    q = f / SIG_STRIDE;
    r.hit  = (f != 0) && (f % SIG_STRIDE == 0) && (esf ? (q <= 4) : (q <= 2));
    r.last = esf ? (q == 4) : (q == 2);
    r.pos  = 2'(4 - q);
    return r;
  endfunction

  function automatic sig_nib_t show_nib(input sig_nib_t raw, input logic esf,
                                        input logic [1:0] spare);
    return esf ? raw : {raw[3:2], spare};
  endfunction

endpackage

// File: rtl/rsig_extract.sv
module rsig_extract import t1rs_pkg::*; #(
  parameter int NCH = 24,
  parameter int SW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [4:0]    rx_frame,
  input  logic [SW-1:0] rx_slot,
  input  logic          sig_bit,
  input  logic          esf,
  input  logic          mf_sync,
  output logic          done,
  output logic [SW-1:0] done_slot,
  output sig_nib_t      done_nib
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NCH - 1);

  sig_nib_t    part [NCH];
  frame_role_t role;
  logic        take;
  sig_nib_t    nib_next;

  always_comb begin
    role     = frame_role(rx_frame, esf);
    take     = rx_valid && mf_sync && role.hit && (rx_slot <= LAST_SLOT);
    nib_next = (rx_slot <= LAST_SLOT) ? part[rx_slot] : '0;
    if (role.pos == 2'd3) nib_next = '0;
    nib_next[role.pos] = sig_bit;
    if (!esf) nib_next[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) part[i] <= '0;
    end else if (take) begin
      part[rx_slot] <= nib_next;
    end
  end

  assign done      = take && role.last;
  assign done_slot = rx_slot;
  assign done_nib  = nib_next;
endmodule

// File: rtl/rsig_debounce.sv
module rsig_debounce import t1rs_pkg::*; #(
  parameter int NCH         = 24,
  parameter int SW          = 5,
  parameter int DBNC_FRAMES = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [SW-1:0] done_slot,
  input  sig_nib_t      done_nib,
  input  logic          esf,
  input  logic          dbnc_en,
  output logic          wr_en
);
  localparam int AW  = $clog2(DBNC_FRAMES + 1);
  localparam int AWP = AW + 1;
  localparam logic [AW:0] LIM    = AWP'(DBNC_FRAMES);
  localparam logic [AW:0] ST_ESF = AWP'(ESF_MF_FRAMES);
  localparam logic [AW:0] ST_D4  = AWP'(D4_MF_FRAMES);

  sig_nib_t      cand [NCH];
  logic [AW-1:0] age  [NCH];
  logic          same;
  logic [AW:0]   sum;
  logic [AW-1:0] age_sat;

  always_comb begin
    same    = (done_nib == cand[done_slot]);
    sum     = {1'b0, age[done_slot]} + (esf ? ST_ESF : ST_D4);
    age_sat = (sum >= LIM) ? LIM[AW-1:0] : sum[AW-1:0];
    wr_en   = done && (!dbnc_en || (same && (sum >= LIM)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        cand[i] <= '0;
        age[i]  <= '0;
      end
    end else if (done) begin
      if (same) begin
        age[done_slot] <= age_sat;
      end else begin
        cand[done_slot] <= done_nib;
        age[done_slot]  <= '0;
      end
    end
  end
endmodule

// File: rtl/rsig_store.sv
module rsig_store import t1rs_pkg::*; #(
  parameter int NCH = 24,
  parameter int SW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_addr,
  input  sig_nib_t      wr_data,
  input  logic [SW-1:0] ra_addr,
  output sig_nib_t      ra_data,
  input  logic [SW-1:0] rb_addr,
  output sig_nib_t      rb_data
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NCH - 1);

  sig_nib_t mem [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign ra_data = (ra_addr <= LAST_SLOT) ? mem[ra_addr] : '0;
  assign rb_data = (rb_addr <= LAST_SLOT) ? mem[rb_addr] : '0;
endmodule

// File: rtl/rsig_stream.sv
module rsig_stream import t1rs_pkg::*; #(
  parameter int NCH = 24,
  parameter int CW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strm_en,
  input  logic [CW-1:0] str_ch,
  input  logic [2:0]    str_bit,
  input  sig_nib_t      nib,
  output logic          ser_out,
  output logic          ser_oe
);
  localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

  logic oe_d;

  assign oe_d = strm_en && (str_ch <= LAST_CH) && !str_bit[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_oe  <= 1'b0;
      ser_out <= 1'b0;
    end else begin
      ser_oe  <= oe_d;
      ser_out <= oe_d ? nib[str_bit[1:0]] : 1'b0;
    end
  end
endmodule

// File: rtl/t1_rxsig_capture.sv
module t1_rxsig_capture import t1rs_pkg::*; #(
  parameter int NCH         = 24,
  parameter int STR_CH      = 32,
  parameter int DBNC_FRAMES = 48,
  parameter int SW          = $clog2(NCH),
  parameter int CW          = $clog2(STR_CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [4:0]    rx_frame,
  input  logic [SW-1:0] rx_slot,
  input  logic [7:0]    rx_byte,
  input  logic          esf_mode,
  input  logic          mf_sync,
  input  logic          dbnc_en,
  input  logic [1:0]    spare_bits,
  input  logic          strm_en,
  input  logic [CW-1:0] str_ch,
  input  logic [2:0]    str_bit,
  output logic          ser_out,
  output logic          ser_oe,
  input  logic [SW-1:0] host_addr,
  output logic [3:0]    host_rdata
);
  logic          unused_payload;
  logic          cap_done;
  logic [SW-1:0] cap_slot;
  sig_nib_t      cap_nib;
  logic          cap_wr;
  sig_nib_t      rd_strm;
  sig_nib_t      rd_host;

  assign unused_payload = ^rx_byte[7:1];

  rsig_extract #(.NCH(NCH), .SW(SW)) u_extract (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_frame(rx_frame),
    .rx_slot(rx_slot), .sig_bit(rx_byte[0]), .esf(esf_mode), .mf_sync(mf_sync),
    .done(cap_done), .done_slot(cap_slot), .done_nib(cap_nib)
  );

  rsig_debounce #(.NCH(NCH), .SW(SW), .DBNC_FRAMES(DBNC_FRAMES)) u_debounce (
    .clk(clk), .rst(rst), .done(cap_done), .done_slot(cap_slot),
    .done_nib(cap_nib), .esf(esf_mode), .dbnc_en(dbnc_en), .wr_en(cap_wr)
  );

  rsig_store #(.NCH(NCH), .SW(SW)) u_store (
    .clk(clk), .rst(rst), .wr_en(cap_wr), .wr_addr(cap_slot), .wr_data(cap_nib),
    .ra_addr(str_ch[SW-1:0]), .ra_data(rd_strm),
    .rb_addr(host_addr), .rb_data(rd_host)
  );

  rsig_stream #(.NCH(NCH), .CW(CW)) u_stream (
    .clk(clk), .rst(rst), .strm_en(strm_en), .str_ch(str_ch), .str_bit(str_bit),
    .nib(show_nib(rd_strm, esf_mode, spare_bits)),
    .ser_out(ser_out), .ser_oe(ser_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= (int'(host_addr) < NCH) ? show_nib(rd_host, esf_mode, spare_bits) : '0;
  end
endmodule

// File: rtl/rsig_checker.sv
module rsig_checker #(
  parameter int NCH = 24,
  parameter int SW  = 5,
  parameter int CW  = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          strm_en,
  input logic [CW-1:0] str_ch,
  input logic [2:0]    str_bit,
  input logic          ser_oe,
  input logic          mf_sync,
  input logic          dbnc_en,
  input logic          esf_mode,
  input logic [4:0]    rx_frame,
  input logic [1:0]    spare_bits,
  input logic [SW-1:0] host_addr,
  input logic [3:0]    host_rdata,
  input logic          cap_done,
  input logic          cap_wr
);
  assert_oe_reset_R8: assert property (@(posedge clk) rst |=> !ser_oe);

  assert_oe_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !strm_en |=> !ser_oe);

  assert_oe_range_R7: assert property (@(posedge clk) disable iff (rst)
    ((int'(str_ch) >= NCH) || str_bit[2]) |=> !ser_oe);

  assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    !mf_sync |-> !cap_wr);

  assert_no_debounce_R5: assert property (@(posedge clk) disable iff (rst)
    (cap_done && !dbnc_en) |-> cap_wr);

  assert_d4_complete_R2: assert property (@(posedge clk) disable iff (rst)
    (cap_done && !esf_mode) |-> (rx_frame == 5'd12));

  assert_spare_shown_R3: assert property (@(posedge clk) disable iff (rst)
    (!esf_mode && (int'(host_addr) < NCH)) |=> (host_rdata[1:0] == $past(spare_bits)));
endmodule

bind t1_rxsig_capture rsig_checker #(.NCH(NCH), .SW(SW), .CW(CW)) i_rsig_checker (
  .clk(clk), .rst(rst), .strm_en(strm_en), .str_ch(str_ch), .str_bit(str_bit),
  .ser_oe(ser_oe), .mf_sync(mf_sync), .dbnc_en(dbnc_en), .esf_mode(esf_mode),
  .rx_frame(rx_frame), .spare_bits(spare_bits), .host_addr(host_addr),
  .host_rdata(host_rdata), .cap_done(cap_done), .cap_wr(cap_wr)
);

// File: tb/test_t1_rxsig_capture.sv
`timescale 1ns/1ps
module test_t1_rxsig_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [4:0] rx_frame = '0;
  logic [4:0] rx_slot = '0;
  logic [7:0] rx_byte = '0;
  logic       esf_mode = 1'b1;
  logic       mf_sync = 1'b1;
  logic       dbnc_en = 1'b0;
  logic [1:0] spare_bits = 2'b00;
  logic       strm_en = 1'b1;
  logic [4:0] str_ch = '0;
  logic [2:0] str_bit = 3'd3;
  logic       ser_out, ser_oe;
  logic [4:0] host_addr = '0;
  logic [3:0] host_rdata;

  int nvec = 0;
  int nerr = 0;
  logic [3:0] want [24];
  logic [3:0] cur  [24];

  always #2.5 clk = ~clk;

  t1_rxsig_capture i_t1_rxsig_capture (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_frame(rx_frame), .rx_slot(rx_slot),
    .rx_byte(rx_byte), .esf_mode(esf_mode), .mf_sync(mf_sync), .dbnc_en(dbnc_en),
    .spare_bits(spare_bits), .strm_en(strm_en), .str_ch(str_ch), .str_bit(str_bit),
    .ser_out(ser_out), .ser_oe(ser_oe), .host_addr(host_addr), .host_rdata(host_rdata)
  );

  function automatic logic [3:0] pat(input int ch, input int seed);
    return 4'((ch * 5 + seed) & 15);
  endfunction

  function automatic logic [3:0] shown(input int ch);
    return esf_mode ? cur[ch] : {cur[ch][3:2], spare_bits};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_want(input int seed);
    for (int ch = 0; ch < 24; ch++) want[ch] = pat(ch, seed);
  endtask

  task automatic send_frames(input int lo, input int hi);
    for (int fr = lo; fr <= hi; fr++) begin
      for (int ch = 0; ch < 24; ch++) begin
        logic b;
        if (fr % 6 == 0) b = want[ch][4 - fr / 6];
        else             b = 1'((ch + fr) & 1);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_frame = 5'(fr);
        rx_slot  = 5'(ch);
        rx_byte  = {7'((ch * 3 + fr) & 127), b};
      end
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic read_chk(input int a, input int exp, input string req);
    @(negedge clk);
    host_addr = 5'(a);
    @(negedge clk);
    check(req, int'(host_rdata), exp);
  endtask

  task automatic check_all(input string req);
    for (int ch = 0; ch < 24; ch++) read_chk(ch, int'(shown(ch)), req);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R8 oe low in reset", int'(ser_oe), 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 oe after reset", int'(ser_oe), 1);
    for (int ch = 0; ch < 24; ch++) cur[ch] = 4'h0;
    check_all("R10 reset nibble");
  endtask

  task automatic t_esf_capture;
    esf_mode = 1'b1; dbnc_en = 1'b0; mf_sync = 1'b1;
    set_want(3);
    send_frames(1, 24);
    for (int ch = 0; ch < 24; ch++) cur[ch] = want[ch];
    check_all("R1 R5 esf capture");
    read_chk(3, int'(cur[3]), "R9 reread first");
    read_chk(3, int'(cur[3]), "R9 reread second");
    for (int a = 24; a < 32; a++) read_chk(a, 0, "R9 unused address");
  endtask

  task automatic t_stream;
    for (int en = 1; en >= 0; en--) begin
      strm_en = 1'(en);
      for (int c = 0; c < 32; c++) begin
        for (int b = 7; b >= 0; b--) begin
          @(negedge clk);
          str_ch = 5'(c); str_bit = 3'(b);
          @(negedge clk);
          if (en == 1 && c < 24 && b < 4) begin
            check("R7 stream oe", int'(ser_oe), 1);
            check("R7 stream bit", int'(ser_out), int'(cur[c][b]));
          end else if (en == 1) begin
            check("R7 stream tristate", int'(ser_oe), 0);
          end else begin
            check("R8 stream disabled", int'(ser_oe), 0);
          end
        end
      end
    end
    strm_en = 1'b1;
  endtask

  task automatic t_d4;
    esf_mode = 1'b0; spare_bits = 2'b10;
    set_want(7);
    send_frames(1, 12);
    for (int ch = 0; ch < 24; ch++) cur[ch] = {want[ch][3:2], 2'b00};
    check_all("R2 d4 capture");
    spare_bits = 2'b01;
    check_all("R3 spare follows");
    @(negedge clk); str_ch = 5'd2; str_bit = 3'd0;
    @(negedge clk);
    check("R3 spare on stream", int'(ser_out), 1);
    set_want(8);
    send_frames(13, 24);
    check_all("R2 later frames ignored");
  endtask

  task automatic t_freeze;
    esf_mode = 1'b1; mf_sync = 1'b0;
    set_want(9);
    send_frames(1, 24);
    check_all("R4 frozen");
    mf_sync = 1'b1;
    send_frames(1, 24);
    for (int ch = 0; ch < 24; ch++) cur[ch] = want[ch];
    check_all("R4 resumed");
  endtask

  task automatic t_debounce;
    dbnc_en = 1'b1;
    set_want(11);
    send_frames(1, 24);
    check_all("R6 first sight held");
    send_frames(1, 24);
    check_all("R6 24 frames held");
    send_frames(1, 24);
    for (int ch = 0; ch < 24; ch++) cur[ch] = want[ch];
    check_all("R6 48 frames commit");
    set_want(13); send_frames(1, 24); send_frames(1, 24);
    set_want(14); send_frames(1, 24);
    set_want(13); send_frames(1, 24);
    check_all("R6 glitch restarts");
    dbnc_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    t_reset();
    t_esf_capture();
    t_stream();
    t_d4();
    t_freeze();
    t_debounce();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule